// File: doc/BRIEF.md
# Low-Power Timer Mode Controller

This block decides when a small microcontroller sleeps in its deepest timer state and how it wakes up. Software in sub-clock run mode writes a control register; when the write asks for timer mode, the clock unit reports sub-clock operation and no enabled interrupt is waiting, the controller turns off every clock except the sub-clock and the watch timer. While asleep, one register bit decides whether the external pins keep their last value or float.

Two events end the sleep. An interrupt request whose level is enabled sends the controller straight back to run mode, with no reset toward storage. A reset request instead moves it into a stabilization wait. That wait is timed by a counter running on the sub-clock, with the length picked by a 2-bit field in the register. When the wait is over, a one-cycle strobe lets the reset sequence go ahead.

The states are RUN (sub-clock run), TIMER (deep sleep) and STAB (oscillation-stabilization wait). The transitions are: RUN to TIMER on an accepted entry write; TIMER to RUN on a wake interrupt; TIMER to STAB on a reset request; STAB to RUN when the wait counter expires.

Top module: `lpm_timer_ctrl`

## Requirements
- R1: After reset the mode output is RUN (2'b00), the core clock enable is 1, both pin controls and the release strobe are 0, and the register reads 8'h01. Register layout: bit 0 is the sleep-request bit (reads 1 when awake), bit 1 is the pin-float select, bits 3:2 select the wait length, and bits 7:4 read 0.
- R2: In RUN, a register write with bit 0 = 0 while scs = 0 and no interrupt is pending puts the mode at TIMER (2'b01) from the next cycle, and bit 0 then reads 0.
- R3: In TIMER and STAB the core clock enable is 0, while the sub-clock and watch-timer enables stay at 1.
- R4: A write made while scs = 1 leaves bit 0 and the mode unchanged, but it still updates bits 3:1.
- R5: A pending interrupt blocks entry: if irq_valid = 1 with a level other than 3'b111 during the entry write, the mode stays RUN and bit 0 stays 1. A request at level 3'b111 does not block.
- R6: With bit 1 = 0, pin_hold = 1 in TIMER and STAB; with bit 1 = 1, pin_hiz = 1 in those states. In RUN both are 0.
- R7: In TIMER, an interrupt at level 3'b111 does not wake the block.
- R8: In TIMER, an interrupt at any level except 3'b111 returns the mode to RUN on the next cycle. Bit 0 reads 1 and rst_release stays 0.
- R9: In TIMER, rst_req moves the mode to STAB (2'b10) on the next cycle. STAB lasts exactly 2^E cycles, where E is WAIT_EXP indexed by bits 3:2. A reset request wins over an interrupt that arrives in the same cycle.
- R10: When the wait expires, the mode returns to RUN and rst_release is 1 for exactly that first RUN cycle. Bit 0 reads 1.
- R11: rst_req in RUN has no effect: the mode stays RUN and rst_release stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scs | input | 1 | Clock select from the clock unit; 0 means sub-clock operation |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| irq_valid | input | 1 | Interrupt request present |
| irq_level | input | 3 | Level of the request; 3'b111 means disabled |
| rst_req | input | 1 | Reset request during sleep |
| mode | output | 2 | Current state: 00 RUN, 01 TIMER, 10 STAB |
| core_clk_en | output | 1 | Enable for every clock except sub-clock and watch timer |
| sub_clk_en | output | 1 | Sub-clock domain enable |
| watch_clk_en | output | 1 | Watch-timer clock enable |
| pin_hold | output | 1 | Pins keep their last state |
| pin_hiz | output | 1 | Pins go high impedance |
| rst_release | output | 1 | One-cycle strobe that releases the reset sequence |

## Verification
Every input reaches the outputs through exactly one state register. The bench drives inputs at a falling edge in cycle c, and the scoreboard expects the mode, clock enables, pin controls and readback at the falling edge of cycle c+1. A reset request in cycle c gives STAB from c+1 through c+2^E, a release strobe at c+2^E+1, and a quiet strobe at c+2^E+2. Each expectation is queued with its due cycle. The monitor pops items only on that exact cycle and counts a late item as a failure.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_TIMER = 2'b01,
        PM_STAB  = 2'b10
    } pm_state_e;

    localparam int CTL_W       = 8;
    localparam int BIT_TMD     = 0;
    localparam int BIT_SPL     = 1;
    localparam int BIT_WSEL_LO = 2;

    localparam logic [2:0] IRQ_LVL_OFF = 3'b111;

endpackage

// File: rtl/pmc_regs.sv
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              scs,
    input  logic              irq_pend,
    input  logic              tm_exit,
    output logic              tmd,
    output logic              spl,
    output logic [WSEL_W-1:0] wsel,
    output logic [CTL_W-1:0]  rdata,
    output logic              enter_req
);

    localparam int USED_W = WSEL_W + 2;

    logic [CTL_W-1:USED_W] unused_wdata_hi;
    assign unused_wdata_hi = wdata[CTL_W-1:USED_W];

    // entry is accepted only from sub-clock operation with nothing pending
    assign enter_req = wr_ok && !scs && !wdata[BIT_TMD] && !irq_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmd  <= 1'b1;
            spl  <= 1'b0;
            wsel <= '0;
        end else begin
            if (tm_exit) begin
                tmd <= 1'b1;
            end else if (wr_ok && !scs) begin
                tmd <= wdata[BIT_TMD] | irq_pend;
            end
            if (wr_ok) begin
                spl  <= wdata[BIT_SPL];
                wsel <= wdata[BIT_WSEL_LO +: WSEL_W];
            end
        end
    end

    assign rdata = CTL_W'({wsel, spl, tmd});

endmodule

// File: rtl/pmc_stab_timer.sv
module pmc_stab_timer #(
    parameter int          WSEL_W = 2,
    parameter int unsigned WAIT_EXP [1<<WSEL_W] = '{10, 13, 15, 17}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WSEL_W-1:0] wsel,
    input  logic              active,
    output logic              expired
);

    localparam int NSEL = 1 << WSEL_W;

    function automatic int unsigned widest();
        int unsigned m;
        m = 1;
        for (int i = 0; i < NSEL; i++) begin
            if (WAIT_EXP[i] > m) m = WAIT_EXP[i];
        end
        return m;
    endfunction

    localparam int CNT_W = int'(widest());

    logic [CNT_W-1:0] load_tbl [NSEL];
    logic [CNT_W-1:0] cnt;

    for (genvar gi = 0; gi < NSEL; gi++) begin : g_load
        assign load_tbl[gi] = CNT_W'((64'd1 << WAIT_EXP[gi]) - 64'd1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_tbl[wsel];
        end else if (active && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = active && (cnt == '0);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enter_req,
    input  logic      irq_wake,
    input  logic      rst_req,
    input  logic      stab_expired,
    output pm_state_e state,
    output logic      tm_exit,
    output logic      stab_load,
    output logic      stab_active,
    output logic      rel
);

    pm_state_e state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            PM_RUN:   if (enter_req) state_nx = PM_TIMER;
            PM_TIMER: begin
                if (rst_req)       state_nx = PM_STAB;
                else if (irq_wake) state_nx = PM_RUN;
            end
            PM_STAB:  if (stab_expired) state_nx = PM_RUN;
            default:  state_nx = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel <= 1'b0;
        else        rel <= (state == PM_STAB) && stab_expired;
    end

    assign tm_exit     = (state == PM_TIMER) && (rst_req || irq_wake);
    assign stab_load   = (state == PM_TIMER) && rst_req;
    assign stab_active = (state == PM_STAB);

endmodule

// File: rtl/pmc_outmap.sv
module pmc_outmap
    import pmc_pkg::*;
(
    input  pm_state_e state,
    input  logic      spl,
    output logic      core_clk_en,
    output logic      sub_clk_en,
    output logic      watch_clk_en,
    output logic      pin_hold,
    output logic      pin_hiz
);

    always_comb begin
        sub_clk_en   = 1'b1;
        watch_clk_en = 1'b1;
        unique case (state)
            PM_RUN: begin
                core_clk_en = 1'b1;
                pin_hold    = 1'b0;
                pin_hiz     = 1'b0;
            end
            PM_TIMER, PM_STAB: begin
                core_clk_en = 1'b0;
                pin_hold    = !spl;
                pin_hiz     = spl;
            end
            default: begin
                core_clk_en = 1'b1;
                pin_hold    = 1'b0;
                pin_hiz     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpm_timer_ctrl.sv
module lpm_timer_ctrl
    import pmc_pkg::*;
#(
    parameter int          WSEL_W = 2,
    parameter int unsigned WAIT_EXP [1<<WSEL_W] = '{10, 13, 15, 17}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scs,
    input  logic                reg_wr,
    input  logic [CTL_W-1:0]    reg_wdata,
    output logic [CTL_W-1:0]    reg_rdata,
    input  logic                irq_valid,
    input  logic [2:0]          irq_level,
    input  logic                rst_req,
    output logic [1:0]          mode,
    output logic                core_clk_en,
    output logic                sub_clk_en,
    output logic                watch_clk_en,
    output logic                pin_hold,
    output logic                pin_hiz,
    output logic                rst_release
);

    pm_state_e         state;
    logic              irq_qual;
    logic              wr_ok;
    logic              tmd;
    logic              spl;
    logic [WSEL_W-1:0] wsel;
    logic              enter_req;
    logic              tm_exit;
    logic              stab_load;
    logic              stab_active;
    logic              stab_expired;

    assign irq_qual = irq_valid && (irq_level != IRQ_LVL_OFF);
    assign wr_ok    = reg_wr && (state == PM_RUN);

    pmc_regs #(.WSEL_W(WSEL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .wdata     (reg_wdata),
        .scs       (scs),
        .irq_pend  (irq_qual),
        .tm_exit   (tm_exit),
        .tmd       (tmd),
        .spl       (spl),
        .wsel      (wsel),
        .rdata     (reg_rdata),
        .enter_req (enter_req)
    );

    pmc_stab_timer #(.WSEL_W(WSEL_W), .WAIT_EXP(WAIT_EXP)) u_stab (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (stab_load),
        .wsel    (wsel),
        .active  (stab_active),
        .expired (stab_expired)
    );

    pmc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_req    (enter_req),
        .irq_wake     (irq_qual),
        .rst_req      (rst_req),
        .stab_expired (stab_expired),
        .state        (state),
        .tm_exit      (tm_exit),
        .stab_load    (stab_load),
        .stab_active  (stab_active),
        .rel          (rst_release)
    );

    pmc_outmap u_out (
        .state        (state),
        .spl          (spl),
        .core_clk_en  (core_clk_en),
        .sub_clk_en   (sub_clk_en),
        .watch_clk_en (watch_clk_en),
        .pin_hold     (pin_hold),
        .pin_hiz      (pin_hiz)
    );

    assign mode = state;

    logic unused_tmd;
    assign unused_tmd = tmd;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scs,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       irq_valid,
    input logic [2:0] irq_level,
    input logic       rst_req,
    input logic [1:0] mode,
    input logic       core_clk_en,
    input logic       sub_clk_en,
    input logic       watch_clk_en,
    input logic       pin_hold,
    input logic       pin_hiz,
    input logic       rst_release
);

    assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && $past(mode) == 2'b00) |->
        $past(reg_wr && !reg_wdata[0] && !scs && !(irq_valid && irq_level != 3'b111)));

    assert_sleep_clocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> (!core_clk_en && sub_clk_en && watch_clk_en));

    assert_pin_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> (pin_hiz == reg_rdata[1] && pin_hold == !reg_rdata[1]));

    assert_masked_no_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && irq_valid && irq_level == 3'b111 && !rst_req) |=> (mode == 2'b01));

    assert_irq_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && irq_valid && irq_level != 3'b111 && !rst_req) |=>
        (mode == 2'b00 && !rst_release && reg_rdata[0]));

    assert_reset_to_stab_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && rst_req) |=> (mode == 2'b10));

    assert_release_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_release |-> (mode == 2'b00 && $past(mode) == 2'b10));

    assert_run_reset_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && rst_req && !reg_wr) |=> (mode == 2'b00 && !rst_release));

    assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);

endmodule

bind lpm_timer_ctrl pmc_checker u_pmc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .scs          (scs),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_valid    (irq_valid),
    .irq_level    (irq_level),
    .rst_req      (rst_req),
    .mode         (mode),
    .core_clk_en  (core_clk_en),
    .sub_clk_en   (sub_clk_en),
    .watch_clk_en (watch_clk_en),
    .pin_hold     (pin_hold),
    .pin_hiz      (pin_hiz),
    .rst_release  (rst_release)
);

// File: tb/test_lpm_timer_ctrl.sv
`timescale 1ns/1ps
module test_lpm_timer_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scs = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_valid = 1'b0;
    logic [2:0] irq_level = 3'b111;
    logic       rst_req = 1'b0;
    logic [1:0] mode;
    logic       core_clk_en, sub_clk_en, watch_clk_en;
    logic       pin_hold, pin_hiz, rst_release;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lpm_timer_ctrl #(.WSEL_W(2), .WAIT_EXP('{2, 3, 4, 5})) i_lpm_timer_ctrl (
        .clk(clk), .rst_n(rst_n), .scs(scs), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_level(irq_level), .rst_req(rst_req), .mode(mode),
        .core_clk_en(core_clk_en), .sub_clk_en(sub_clk_en),
        .watch_clk_en(watch_clk_en), .pin_hold(pin_hold), .pin_hiz(pin_hiz),
        .rst_release(rst_release)
    );

    typedef struct {
        int         due;
        logic [1:0] md;
        logic       core;
        logic       hold;
        logic       hiz;
        logic       rel;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t q[$];

    task automatic push(int due, logic [1:0] md, logic core, logic hold,
                        logic hiz, logic rel, logic [7:0] rd, string tag);
        exp_t e;
        e.due = due; e.md = md; e.core = core; e.hold = hold;
        e.hiz = hiz; e.rel = rel; e.rd = rd; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_run(int due, logic [7:0] rd, logic rel, string tag);
        push(due, 2'b00, 1'b1, 1'b0, 1'b0, rel, rd, tag);
    endtask

    task automatic exp_sleep(int due, logic [1:0] md, logic spl, logic [7:0] rd, string tag);
        push(due, md, 1'b0, !spl, spl, 1'b0, rd, tag);
    endtask

    // drive at a falling edge; returns the cycle index of that edge
    task automatic apply(logic wr, logic [7:0] wd, logic s, logic iv,
                         logic [2:0] il, logic rr, output int c);
        @(negedge clk);
        c = cyc;
        reg_wr = wr; reg_wdata = wd; scs = s;
        irq_valid = iv; irq_level = il; rst_req = rr;
    endtask

    task automatic step();
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 8'h00; scs = 1'b0;
        irq_valid = 1'b0; irq_level = 3'b111; rst_req = 1'b0;
    endtask

    task automatic wait_past(int due);
        while (cyc <= due) @(negedge clk);
    endtask

    // monitor: compares each expected item on its due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (e.due != cyc) begin
                fails++;
                $display("FAIL %s: item due at %0d checked at %0d", e.tag, e.due, cyc);
            end else if (mode !== e.md || core_clk_en !== e.core || pin_hold !== e.hold ||
                         pin_hiz !== e.hiz || rst_release !== e.rel || reg_rdata !== e.rd ||
                         sub_clk_en !== 1'b1 || watch_clk_en !== 1'b1) begin
                fails++;
                $display("FAIL %s @%0d: got mode=%0d core=%0b sub=%0b watch=%0b hold=%0b hiz=%0b rel=%0b rd=%h exp mode=%0d core=%0b sub=1 watch=1 hold=%0b hiz=%0b rel=%0b rd=%h",
                         e.tag, cyc, mode, core_clk_en, sub_clk_en, watch_clk_en, pin_hold,
                         pin_hiz, rst_release, reg_rdata, e.md, e.core, e.hold, e.hiz,
                         e.rel, e.rd);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got cycle %0d exp < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        c = cyc;
        rst_n = 1'b1;
        exp_run(c + 1, 8'h01, 1'b0, "R1 reset state");
        wait_past(c + 1);

        // R2 / R3 / R6: entry with pins held
        apply(1, 8'h00, 0, 0, 3'b111, 0, c);
        exp_sleep(c + 1, 2'b01, 1'b0, 8'h00, "R2 R3 R6 timer entry, pins hold");
        step(); wait_past(c + 1);

        // R7: disabled level does not wake
        apply(0, 8'h00, 0, 1, 3'b111, 0, c);
        exp_sleep(c + 1, 2'b01, 1'b0, 8'h00, "R7 level 111 ignored");
        step(); wait_past(c + 1);

        // R8: enabled level wakes, no release strobe
        apply(0, 8'h00, 0, 1, 3'b011, 0, c);
        exp_run(c + 1, 8'h01, 1'b0, "R8 interrupt wake");
        exp_run(c + 2, 8'h01, 1'b0, "R8 no strobe after wake");
        step(); wait_past(c + 2);

        // R4: sleep request with scs = 1 is ignored, other bits land
        apply(1, 8'h02, 1, 0, 3'b111, 0, c);
        exp_run(c + 1, 8'h03, 1'b0, "R4 scs=1 write");
        step(); wait_past(c + 1);

        // R5: pending interrupt blocks entry
        apply(1, 8'h02, 0, 1, 3'b010, 0, c);
        exp_run(c + 1, 8'h03, 1'b0, "R5 pending blocks entry");
        step(); wait_past(c + 1);

        // R6: entry with pins floated, wait select 1
        apply(1, 8'h06, 0, 0, 3'b111, 0, c);
        exp_sleep(c + 1, 2'b01, 1'b1, 8'h06, "R6 timer entry, pins float");
        step(); wait_past(c + 1);

        // R9 / R10: reset exit through an 8-cycle wait
        apply(0, 8'h00, 0, 0, 3'b111, 1, c);
        exp_sleep(c + 1, 2'b10, 1'b1, 8'h07, "R9 stab entry");
        exp_sleep(c + 8, 2'b10, 1'b1, 8'h07, "R9 stab last cycle");
        exp_run(c + 9, 8'h07, 1'b1, "R10 release strobe");
        exp_run(c + 10, 8'h07, 1'b0, "R10 strobe one cycle");
        step(); wait_past(c + 10);

        // R11: reset request in run mode
        apply(0, 8'h00, 0, 0, 3'b111, 1, c);
        exp_run(c + 1, 8'h07, 1'b0, "R11 run reset ignored");
        exp_run(c + 2, 8'h07, 1'b0, "R11 no later strobe");
        step(); wait_past(c + 2);

        // R9 priority: reset and interrupt together, 4-cycle wait
        apply(1, 8'h00, 0, 0, 3'b111, 0, c);
        exp_sleep(c + 1, 2'b01, 1'b0, 8'h00, "R2 re-entry");
        step(); wait_past(c + 1);
        apply(0, 8'h00, 0, 1, 3'b001, 1, c);
        exp_sleep(c + 1, 2'b10, 1'b0, 8'h01, "R9 reset beats interrupt");
        exp_sleep(c + 4, 2'b10, 1'b0, 8'h01, "R9 stab length 4");
        exp_run(c + 5, 8'h01, 1'b1, "R10 release after 4");
        exp_run(c + 6, 8'h01, 1'b0, "R10 strobe ends");
        step(); wait_past(c + 6);

        // R5: level 111 request does not block entry
        apply(1, 8'h00, 0, 1, 3'b111, 0, c);
        exp_sleep(c + 1, 2'b01, 1'b0, 8'h00, "R5 disabled request does not block");
        step(); wait_past(c + 1);
        apply(0, 8'h00, 0, 1, 3'b000, 0, c);
        exp_run(c + 1, 8'h01, 1'b0, "R8 level 000 wakes");
        step(); wait_past(c + 1);

        // R9: longest selection, 32-cycle wait
        apply(1, 8'h0C, 0, 0, 3'b111, 0, c);
        exp_sleep(c + 1, 2'b01, 1'b0, 8'h0C, "R2 entry sel 3");
        step(); wait_past(c + 1);
        apply(0, 8'h00, 0, 0, 3'b111, 1, c);
        exp_sleep(c + 1, 2'b10, 1'b0, 8'h0D, "R9 stab sel 3 start");
        exp_sleep(c + 32, 2'b10, 1'b0, 8'h0D, "R9 stab sel 3 last");
        exp_run(c + 33, 8'h0D, 1'b1, "R10 release after 32");
        exp_run(c + 34, 8'h0D, 1'b0, "R10 strobe ends sel 3");
        step(); wait_past(c + 34);

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule